// File: doc/BRIEF.md
# Fetch-Decode Control Sequencer

This block is the control sequencer of a small 16-bit accumulator machine. It covers the fetch and decode phases of the instruction cycle. It reads instruction words from a synchronous memory with one read port. It latches each word into an instruction register and splits that word into three parts: an indirect flag, a 3-bit opcode and a 12-bit address register. A memory-reference instruction marked indirect gets one more clock. In that clock the address register is reloaded from the memory word it points to.

The sequencer sorts each instruction into one of three classes: memory-reference, register-reference or I/O. Register-reference and I/O words carry a bit pattern, and the block checks that pattern. An illegal pattern raises a sticky trap and stops the machine. Instruction semantics are outside this block. While the decoded fields are valid, an execute request is held high. An execute stub answers it with a done pulse, and it also drives a halt line when the instruction is a halt. A run flag gates the whole loop. A cycle counter advances on every clock in which that flag is set.

Top module: `fd_sequencer`

## Requirements
- R1: After synchronous reset the run flag is 1, the trap is 0, the program counter equals the RESET_PC parameter, the cycle counter is 0, and fetching begins on the next clock.
- R2: Fetch takes two clocks. In the first clock a memory read is issued at the program counter and the address register is loaded with the program counter. In the second clock the returned word is loaded into the instruction register and the program counter increments by one.
- R3: Decode takes one clock, in which three fields are loaded from the instruction word. Bit 15 goes to the indirect flag. Bits 14..12 go to the opcode register. Bits 11..0 always go to the address register.
- R4: When the opcode is 0 to 6 and bit 15 is 1, decode takes a second clock. A read is issued at bits 11..0, and the address register is then loaded with bits 11..0 of the returned word. Opcode 7 never takes this extra clock.
- R5: Class output encoding is 0 for a memory-reference instruction (opcode 0 to 6), 1 for a register-reference instruction (opcode 7, bit 15 = 0) and 2 for an I/O instruction (opcode 7, bit 15 = 1).
- R6: With opcode 7, the instruction is legal only when exactly one of bits 11..0 is set. Any other pattern sets the trap output and clears the run flag at the end of decode. No execute request is raised for that word, and the trap holds until reset.
- R7: After decode, the execute request stays high with the class and fields stable until execute-done is sampled high. The next fetch then starts on the following clock.
- R8: Halt sampled high together with execute-done during an execute request clears the run flag. While the run flag is 0, no memory read and no execute request occurs.
- R9: The cycle counter increments on every clock edge at which the run flag is 1 and holds otherwise. With a single-clock execute, a direct instruction spans 4 clocks and an indirect memory-reference instruction spans 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_rd_en_o | output | 1 | Memory read strobe; data returns one clock later |
| mem_rdata_i | input | OPC_W+ADDR_W+1 | Memory read data |
| exec_req_o | output | 1 | Decoded instruction ready for execution |
| exec_done_i | input | 1 | Execute stub finished |
| halt_i | input | 1 | Execute stub reports a halt instruction |
| class_o | output | 2 | Instruction class (0 memory, 1 register, 2 I/O) |
| trap_o | output | 1 | Illegal instruction trap, sticky |
| run_o | output | 1 | Run flag |
| ind_o | output | 1 | Indirect flag |
| opc_o | output | OPC_W | Opcode register |
| ar_o | output | ADDR_W | Address register |
| ir_o | output | OPC_W+ADDR_W+1 | Instruction register |
| pc_o | output | ADDR_W | Program counter |
| cycle_o | output | CNT_W | Cycle counter |

## Verification
The bench keeps the default 3-bit opcode and 12-bit address widths, so the single-set-bit legality check is tried at every position of the full address field. It sets RESET_PC to 16, which separates the fetch address from zero and from the pointer region, so that a wrong source on the address mux shows up as a wrong instruction word. Random execute-done stalls in one program lengthen the execute phase while the per-instruction cycle counts are still checked.

// File: rtl/fd_pkg.sv
package fd_pkg;

  typedef enum logic [2:0] {
    ST_FETCH_A  = 3'd0,
    ST_FETCH_D  = 3'd1,
    ST_DECODE   = 3'd2,
    ST_INDIRECT = 3'd3,
    ST_EXEC     = 3'd4,
    ST_STOP     = 3'd5
  } fd_state_e;

  typedef enum logic [1:0] {
    CLS_MEM = 2'd0,
    CLS_REG = 2'd1,
    CLS_IO  = 2'd2
  } fd_class_e;

endpackage

// File: rtl/fd_classify.sv
module fd_classify
  import fd_pkg::*;
#(
  parameter int OPC_W  = 3,
  parameter int ADDR_W = 12
) (
  input  logic [OPC_W+ADDR_W:0] instr,
  output fd_class_e             cls,
  output logic                  need_ind,
  output logic                  illegal
);

  localparam int IBIT = OPC_W + ADDR_W;

  logic              ind_bit;
  logic [OPC_W-1:0]  opc;
  logic [ADDR_W-1:0] fld;
  logic              special;
  logic              single_bit;

  always_comb begin
    ind_bit    = instr[IBIT];
    opc        = instr[ADDR_W +: OPC_W];
    fld        = instr[ADDR_W-1:0];
    special    = &opc;
    single_bit = (fld != '0) && ((fld & (fld - ADDR_W'(1))) == '0);
    if (special) cls = ind_bit ? CLS_IO : CLS_REG;
    else         cls = CLS_MEM;
    need_ind   = !special && ind_bit;
    illegal    = special && !single_bit;
  end

endmodule

// File: rtl/fd_ctrl.sv
module fd_ctrl
  import fd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      need_ind,
  input  logic      illegal,
  input  logic      exec_done,
  input  logic      halt,
  output fd_state_e state,
  output logic      run,
  output logic      trap
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FETCH_A;
      run   <= 1'b1;
      trap  <= 1'b0;
    end else begin
      case (state)
        ST_FETCH_A:  state <= ST_FETCH_D;
        ST_FETCH_D:  state <= ST_DECODE;
        ST_DECODE: begin
          if (illegal) begin
            state <= ST_STOP;
            run   <= 1'b0;
            trap  <= 1'b1;
          end else if (need_ind) begin
            state <= ST_INDIRECT;
          end else begin
            state <= ST_EXEC;
          end
        end
        ST_INDIRECT: state <= ST_EXEC;
        ST_EXEC: begin
          if (exec_done) begin
            if (halt) begin
              state <= ST_STOP;
              run   <= 1'b0;
            end else begin
              state <= ST_FETCH_A;
            end
          end
        end
        default:     state <= ST_STOP;
      endcase
    end
  end

endmodule

// File: rtl/fd_datapath.sv
module fd_datapath
  import fd_pkg::*;
#(
  parameter int          OPC_W    = 3,
  parameter int          ADDR_W   = 12,
  parameter int unsigned RESET_PC = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  fd_state_e             state,
  input  logic                  need_ind,
  input  fd_class_e             cls_in,
  input  logic [OPC_W+ADDR_W:0] mem_rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_rd_en,
  output logic [ADDR_W-1:0]     pc,
  output logic [ADDR_W-1:0]     ar,
  output logic [OPC_W+ADDR_W:0] ir,
  output logic                  ind,
  output logic [OPC_W-1:0]      opc,
  output fd_class_e             cls
);

  localparam int IBIT = OPC_W + ADDR_W;

  always_comb begin
    mem_rd_en = (state == ST_FETCH_A) || ((state == ST_DECODE) && need_ind);
    mem_addr  = (state == ST_FETCH_A) ? pc : ir[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= ADDR_W'(RESET_PC);
      ar  <= '0;
      ir  <= '0;
      ind <= 1'b0;
      opc <= '0;
      cls <= CLS_MEM;
    end else begin
      case (state)
        ST_FETCH_A: ar <= pc;
        ST_FETCH_D: begin
          ir <= mem_rdata;
          pc <= pc + ADDR_W'(1);
        end
        ST_DECODE: begin
          ind <= ir[IBIT];
          opc <= ir[ADDR_W +: OPC_W];
          ar  <= ir[ADDR_W-1:0];
          cls <= cls_in;
        end
        ST_INDIRECT: ar <= mem_rdata[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/fd_cycle_ctr.sv
module fd_cycle_ctr #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (run) count <= count + CNT_W'(1);
  end

endmodule

// File: rtl/fd_sequencer.sv
module fd_sequencer
  import fd_pkg::*;
#(
  parameter int          OPC_W    = 3,
  parameter int          ADDR_W   = 12,
  parameter int          CNT_W    = 32,
  parameter int unsigned RESET_PC = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic                  mem_rd_en_o,
  input  logic [OPC_W+ADDR_W:0] mem_rdata_i,
  output logic                  exec_req_o,
  input  logic                  exec_done_i,
  input  logic                  halt_i,
  output logic [1:0]            class_o,
  output logic                  trap_o,
  output logic                  run_o,
  output logic                  ind_o,
  output logic [OPC_W-1:0]      opc_o,
  output logic [ADDR_W-1:0]     ar_o,
  output logic [OPC_W+ADDR_W:0] ir_o,
  output logic [ADDR_W-1:0]     pc_o,
  output logic [CNT_W-1:0]      cycle_o
);

  fd_state_e state;
  fd_class_e cls_dec;
  fd_class_e cls_q;
  logic      need_ind;
  logic      illegal;

  fd_classify #(.OPC_W(OPC_W), .ADDR_W(ADDR_W)) u_cls (
    .instr    (ir_o),
    .cls      (cls_dec),
    .need_ind (need_ind),
    .illegal  (illegal)
  );

  fd_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .need_ind  (need_ind),
    .illegal   (illegal),
    .exec_done (exec_done_i),
    .halt      (halt_i),
    .state     (state),
    .run       (run_o),
    .trap      (trap_o)
  );

  fd_datapath #(.OPC_W(OPC_W), .ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .need_ind  (need_ind),
    .cls_in    (cls_dec),
    .mem_rdata (mem_rdata_i),
    .mem_addr  (mem_addr_o),
    .mem_rd_en (mem_rd_en_o),
    .pc        (pc_o),
    .ar        (ar_o),
    .ir        (ir_o),
    .ind       (ind_o),
    .opc       (opc_o),
    .cls       (cls_q)
  );

  fd_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst   (rst),
    .run   (run_o),
    .count (cycle_o)
  );

  assign exec_req_o = (state == ST_EXEC);
  assign class_o    = cls_q;

endmodule

// File: rtl/fd_sequencer_chk.sv
module fd_sequencer_chk #(
  parameter int OPC_W  = 3,
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              run_o,
  input logic              trap_o,
  input logic              exec_req_o,
  input logic              exec_done_i,
  input logic              halt_i,
  input logic              mem_rd_en_o,
  input logic [1:0]        class_o,
  input logic              ind_o,
  input logic [OPC_W-1:0]  opc_o,
  input logic [ADDR_W-1:0] ar_o,
  input logic [CNT_W-1:0]  cycle_o
);

  assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
    run_o |=> (cycle_o == $past(cycle_o) + CNT_W'(1)));

  assert_count_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !run_o |=> $stable(cycle_o));

  assert_trap_stops_R6: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> !run_o);

  assert_trap_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    trap_o |=> trap_o);

  assert_legal_pattern_R6: assert property (@(posedge clk) disable iff (rst)
    (exec_req_o && class_o != 2'd0) |-> ($countones(ar_o) == 1));

  assert_class_opc_R5: assert property (@(posedge clk) disable iff (rst)
    exec_req_o |-> ((class_o == 2'd0) == (opc_o != {OPC_W{1'b1}})));

  assert_class_ind_R5: assert property (@(posedge clk) disable iff (rst)
    (exec_req_o && class_o != 2'd0) |-> (ind_o == (class_o == 2'd2)));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !run_o |-> (!exec_req_o && !mem_rd_en_o));

  assert_stop_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(run_o) |-> (trap_o || $past(exec_req_o && exec_done_i && halt_i)));

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (exec_req_o && !exec_done_i) |=> (exec_req_o && $stable(ar_o) && $stable(class_o)));

endmodule

bind fd_sequencer fd_sequencer_chk #(.OPC_W(OPC_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .run_o       (run_o),
  .trap_o      (trap_o),
  .exec_req_o  (exec_req_o),
  .exec_done_i (exec_done_i),
  .halt_i      (halt_i),
  .mem_rd_en_o (mem_rd_en_o),
  .class_o     (class_o),
  .ind_o       (ind_o),
  .opc_o       (opc_o),
  .ar_o        (ar_o),
  .cycle_o     (cycle_o)
);

// File: tb/fd_sequencer_tb.sv
`timescale 1ns/1ps
module fd_sequencer_tb;

  localparam int OPC_W  = 3;
  localparam int ADDR_W = 12;
  localparam int CNT_W  = 32;
  localparam int PC0    = 16;
  localparam int NPROG  = 40;
  localparam logic [15:0] HLT = 16'h7001;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic        mem_rd_en;
  logic [15:0] mem_rdata = '0;
  logic        exec_req;
  logic        exec_done = 1'b0;
  logic        halt_i = 1'b0;
  logic [1:0]  class_o;
  logic        trap_o, run_o, ind_o;
  logic [2:0]  opc_o;
  logic [11:0] ar_o, pc_o;
  logic [15:0] ir_o;
  logic [31:0] cycle_o;

  fd_sequencer #(.OPC_W(OPC_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RESET_PC(PC0)) u_dut (
    .clk(clk), .rst(rst), .mem_addr_o(mem_addr), .mem_rd_en_o(mem_rd_en),
    .mem_rdata_i(mem_rdata), .exec_req_o(exec_req), .exec_done_i(exec_done),
    .halt_i(halt_i), .class_o(class_o), .trap_o(trap_o), .run_o(run_o),
    .ind_o(ind_o), .opc_o(opc_o), .ar_o(ar_o), .ir_o(ir_o), .pc_o(pc_o),
    .cycle_o(cycle_o)
  );

  logic [15:0] mem [0:255];
  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr[7:0]];

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_ar(input logic [15:0] w);
    if (w[14:12] != 3'd7 && w[15]) return mem[w[7:0]][11:0];
    return w[11:0];
  endfunction

  function automatic logic [1:0] exp_cls(input logic [15:0] w);
    if (w[14:12] != 3'd7) return 2'd0;
    return w[15] ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [15:0] gen_instr();
    logic [15:0] w;
    case ($urandom % 4)
      0, 1:    w = {1'($urandom), 3'($urandom % 7), 4'($urandom), 1'b1, 7'($urandom)};
      2:       w = 16'h7000 | (16'h1 << (1 + $urandom % 11));
      default: w = 16'hF000 | (16'h1 << ($urandom % 12));
    endcase
    return w;
  endfunction

  // per-instruction monitor
  int          idx;
  logic [31:0] base;
  bit          in_exec;
  bit          stall_en = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      idx = 0; base = '0; in_exec = 1'b0; halt_i = 1'b0; exec_done = 1'b0;
    end else if (exec_req) begin
      if (!in_exec) begin
        logic [15:0] w;
        w = mem[8'(PC0 + idx)];
        in_exec = 1'b1;
        chk("R2 fetched word", 32'(ir_o), 32'(w));
        chk("R2 pc advance", 32'(pc_o), 32'(PC0 + idx + 1));
        chk("R3 indirect flag", 32'(ind_o), 32'(w[15]));
        chk("R3 opcode", 32'(opc_o), 32'(w[14:12]));
        chk("R3/R4 address reg", 32'(ar_o), 32'(exp_ar(w)));
        chk("R5 class", 32'(class_o), 32'(exp_cls(w)));
        chk("R9/R4 decode length", cycle_o,
            base + ((w[14:12] != 3'd7 && w[15]) ? 32'd4 : 32'd3));
      end
      exec_done = stall_en ? (($urandom % 3) != 0) : 1'b1;
      halt_i    = (ir_o == HLT);
      if (exec_done) begin
        base = cycle_o + 32'd1;
        idx++;
        in_exec = 1'b0;
      end
    end else begin
      exec_done = 1'b0;
      halt_i    = 1'b0;
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #0.5;
    chk("R1 run after reset", 32'(run_o), 32'd1);
    chk("R1 trap after reset", 32'(trap_o), 32'd0);
    chk("R1 pc after reset", 32'(pc_o), 32'(PC0));
    chk("R1 counter after reset", cycle_o, 32'd0);
    chk("R1 fetch read issued", 32'(mem_rd_en), 32'd1);
    chk("R2 fetch address", 32'(mem_addr), 32'(PC0));
  endtask

  task automatic wait_stop();
    @(negedge clk);
    while (run_o) @(negedge clk);
  endtask

  task automatic check_frozen(input string tag);
    logic [31:0] c;
    c = cycle_o;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (exec_req || mem_rd_en) chk({tag, " activity while stopped"}, 32'(exec_req | mem_rd_en), 32'd0);
    end
    chk({tag, " counter frozen"}, cycle_o, c);
    chk({tag, " run stays low"}, 32'(run_o), 32'd0);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = (i >= 128) ? 16'($urandom) : 16'h0000;
  endtask

  initial begin
    void'($urandom(32'd1234));

    // program A: directed then random, random execute stalls
    clear_mem();
    mem[PC0 + 0] = 16'h8085;
    mem[PC0 + 1] = 16'hE0FF;
    mem[PC0 + 2] = 16'h3A90;
    mem[PC0 + 3] = 16'hF800;
    mem[PC0 + 4] = 16'h7800;
    mem[PC0 + 5] = 16'h7002;
    mem[PC0 + 6] = 16'hF001;
    for (int i = 7; i < NPROG - 1; i++) mem[PC0 + i] = gen_instr();
    mem[PC0 + NPROG - 1] = HLT;
    stall_en = 1'b1;
    do_reset();
    wait_stop();
    chk("R8 halt without trap", 32'(trap_o), 32'd0);
    chk("R7 all instructions executed", 32'(idx), 32'(NPROG));
    chk("R8 pc after halt", 32'(pc_o), 32'(PC0 + NPROG));
    chk("R9 total cycles", cycle_o, base);
    check_frozen("R8");

    // program B: trap after one indirect instruction
    clear_mem();
    mem[PC0 + 0] = 16'h9085;
    mem[PC0 + 1] = 16'h7003;
    stall_en = 1'b0;
    do_reset();
    wait_stop();
    chk("R6 trap raised two bits", 32'(trap_o), 32'd1);
    chk("R6 no execute for illegal", 32'(idx), 32'd1);
    chk("R6 trap cycle count", cycle_o, base + 32'd3);
    chk("R6 pc at trap", 32'(pc_o), 32'(PC0 + 2));
    check_frozen("R6");
    chk("R6 trap sticky", 32'(trap_o), 32'd1);

    // program C: I/O with no bit set traps at once
    clear_mem();
    mem[PC0 + 0] = 16'hF000;
    do_reset();
    wait_stop();
    chk("R6 trap raised zero bits", 32'(trap_o), 32'd1);
    chk("R6 first-instruction trap cycles", cycle_o, 32'd3);
    chk("R6 no execute at all", 32'(idx), 32'd0);

    // program D: I/O bit 0 is legal and not indirect, then halt
    clear_mem();
    mem[PC0 + 0] = 16'hF001;
    mem[PC0 + 1] = HLT;
    do_reset();
    wait_stop();
    chk("R4 opcode 7 no extra clock", cycle_o, 32'd8);
    chk("R8 halt leaves trap low", 32'(trap_o), 32'd0);
    chk("R7 two executed", 32'(idx), 32'd2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule